// File: doc/BRIEF.md
# Triggered Parent Clock Selector

This block chooses which of several asynchronous parent clocks drives a single output clock. Software writes a code into a selection field that sits at a fixed shift and width inside a 32-bit selection register. The written code is only held as a pending value. Nothing changes at the output until software writes a 1 to the commit bit of a separate trigger register. That bit then reads back 1 for as long as the switch-over is in progress and returns to 0 once the new parent is actually driving the output.

The field can hold more codes than there are parents, and its reset code may be one of the unused ones. A code with no parent behind it gates the output low and commits without any busy period.

When the clock owning the selector has two triggers, the selector answers to the pre-trigger bit and ignores the other one. Register writes and triggers are honoured only while the clock is enabled, and only while no switch-over is pending.

The switch itself uses break-before-make. The old parent is stopped on one of its own falling edges. The new parent is started only after its request has passed two of its own rising edges. The output therefore never sees a shortened high or low phase.

There is no data stream at the edge of this block. All of its pins are plain control and status signals, so there is no valid/ready back-pressure to describe.

Top module: `trig_clk_select`

## Requirements
- R1: After reset the selection register reads the reset code at bits [SEL_SHIFT +: SEL_W]. All other bits of the register always read 0, whatever was written into them.
- R2: A write to the selection register updates the pending code only while `clk_gate_on` is 1. A write made while it is 0 leaves the readback unchanged.
- R3: A write to the selection register while a switch-over is in progress (busy) is ignored. After completion the readback still shows the code that was committed.
- R4: Changing the pending code has no effect on `clk_out` until a commit is triggered.
- R5: Only the commit bit starts a switch, and only while `clk_gate_on` is 1 and no switch is in progress. The commit bit is the pre-trigger bit PRE_TRIG_BIT when HAS_PRE_TRIG is 1, and MAIN_TRIG_BIT otherwise. Writing the other trigger bit, or triggering with the clock disabled, changes neither busy nor `clk_out`.
- R6: Busy reads 1 in `trig_rdata` at the commit bit from the cycle after a commit with a valid code until the switch-over completes. All other bits of `trig_rdata` read 0. Busy clears only once the new parent is driving `clk_out`.
- R7: A code of N_SRC or above (including a reset code in that range) holds `clk_out` at 0. A commit with such a code never shows busy.
- R8: Code k (0 to N_SRC-1) selects `src_clk[k]`. After completion, `clk_out` equals `src_clk[k]` in level, rising and falling with it.
- R9: At any moment at most one parent is gated through. `clk_out` never shows a high or low phase shorter than the shortest half period of the parents, including during a switch-over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register/control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | N_SRC | Parent clocks, mutually asynchronous |
| clk_gate_on | input | 1 | 1 while the owning clock is enabled; changes are accepted only then |
| sel_we | input | 1 | Write strobe for the selection register |
| sel_wdata | input | 32 | Selection register write data |
| sel_rdata | output | 32 | Selection register readback (pending code) |
| trig_we | input | 1 | Write strobe for the trigger register |
| trig_wdata | input | 32 | Trigger register write data |
| trig_rdata | output | 32 | Trigger register readback (busy at the commit bit) |
| clk_out | output | 1 | Selected output clock |

## Verification
The bench builds the block with three parents (half periods 3.5, 5.5 and 8.5 ns) and a 2-bit field at shift 12. This leaves code 3 free, and code 3 is also the reset value, so the no-parent behaviour is reachable straight out of reset and again by a later commit. Pre-trigger mode is on, with the pre-trigger at bit 1 and the main trigger at bit 0, so a write to the wrong trigger bit can be shown to do nothing. Every pair of parents with different speeds is switched in both directions while an edge monitor measures every output phase.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  // Number of flops a request crosses in the destination domain
  localparam int unsigned SYNC_STAGES = 2;

  function automatic logic [31:0] place_field(input logic [31:0] value,
                                              input int unsigned shift);
    return value << shift;
  endfunction
endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [clksel_pkg::SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(clksel_pkg::SYNC_STAGES); s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < int'(clksel_pkg::SYNC_STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[clksel_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/clksel_lane.sv
module clksel_lane (
  input  logic src_clk,
  input  logic rst_n,
  input  logic selected,     // from control domain, registered
  input  logic others_on,    // any other lane gate open, raw
  output logic gate_o
);
  logic [1:0] req_q;
  logic       want;

  assign want = selected && !others_on;

  // two rising edges of this parent before the request counts
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= {req_q[0], want};
  end

  // gate only moves while this parent is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_o <= 1'b0;
    else        gate_o <= req_q[1];
  end
endmodule

// File: rtl/clksel_regs.sv
module clksel_regs #(
  parameter int unsigned N_SRC      = 3,
  parameter int unsigned SEL_SHIFT  = 12,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned SEL_RESET  = 3,
  parameter int unsigned COMMIT_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_on,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             trig_we,
  input  logic [31:0]      trig_wdata,
  output logic [31:0]      trig_rdata,
  input  logic [N_SRC-1:0] lane_on_s,
  output logic [N_SRC-1:0] lane_sel_q,
  output logic             busy_o
);
  localparam logic [31:0] N_SRC_U = 32'(N_SRC);

  logic [SEL_W-1:0] pend_q;
  logic             busy_q;
  logic             cfg_ok, commit, pend_valid, landed;
  logic             unused_bits;

  function automatic logic [N_SRC-1:0] decode(input logic [SEL_W-1:0] code);
    logic [N_SRC-1:0] v;
    v = '0;
    for (int i = 0; i < int'(N_SRC); i++)
      if (32'(code) == 32'(i)) v[i] = 1'b1;
    return v;
  endfunction

  assign cfg_ok     = cfg_we && gate_on && !busy_q;
  assign commit     = trig_we && trig_wdata[COMMIT_BIT] && gate_on && !busy_q;
  assign pend_valid = 32'(pend_q) < N_SRC_U;
  assign landed     = (lane_on_s == lane_sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= SEL_W'(SEL_RESET);
      lane_sel_q <= decode(SEL_W'(SEL_RESET));
      busy_q     <= 1'b0;
    end else begin
      if (cfg_ok) pend_q <= cfg_wdata[SEL_SHIFT +: SEL_W];
      if (commit) begin
        lane_sel_q <= decode(pend_q);
        busy_q     <= pend_valid;
      end else if (busy_q && landed) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign cfg_rdata   = clksel_pkg::place_field(32'(pend_q), SEL_SHIFT);
  assign trig_rdata  = clksel_pkg::place_field(32'(busy_q), COMMIT_BIT);
  assign busy_o      = busy_q;
  assign unused_bits = ^{cfg_wdata, trig_wdata};

  // R2: closed clock blocks field updates
  a_r2_closed_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !gate_on) |=> $stable(pend_q));
  // R3: writes while busy are dropped
  a_r3_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy_q) |=> $stable(pend_q));
  // R5: busy only starts from the commit bit with the clock enabled
  a_r5_commit_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(trig_we && trig_wdata[COMMIT_BIT] && gate_on));
  // R7: a code with no parent never shows busy
  a_r7_void_code: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (32'(pend_q) >= N_SRC_U)) |=> !busy_q);
endmodule

// File: rtl/trig_clk_select.sv
module trig_clk_select #(
  parameter int unsigned N_SRC         = 3,
  parameter int unsigned SEL_SHIFT     = 12,
  parameter int unsigned SEL_W         = 2,
  parameter int unsigned SEL_RESET     = 3,
  parameter bit          HAS_PRE_TRIG  = 1'b1,
  parameter int unsigned MAIN_TRIG_BIT = 0,
  parameter int unsigned PRE_TRIG_BIT  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_clk,
  input  logic             clk_gate_on,
  input  logic             sel_we,
  input  logic [31:0]      sel_wdata,
  output logic [31:0]      sel_rdata,
  input  logic             trig_we,
  input  logic [31:0]      trig_wdata,
  output logic [31:0]      trig_rdata,
  output logic             clk_out
);
  localparam int unsigned COMMIT_BIT = HAS_PRE_TRIG ? PRE_TRIG_BIT : MAIN_TRIG_BIT;

  logic [N_SRC-1:0] lane_sel, gate_raw, lane_on_s, passed;
  logic             busy;

  clksel_regs #(
    .N_SRC(N_SRC), .SEL_SHIFT(SEL_SHIFT), .SEL_W(SEL_W),
    .SEL_RESET(SEL_RESET), .COMMIT_BIT(COMMIT_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .gate_on(clk_gate_on),
    .cfg_we(sel_we), .cfg_wdata(sel_wdata), .cfg_rdata(sel_rdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .trig_rdata(trig_rdata),
    .lane_on_s(lane_on_s), .lane_sel_q(lane_sel), .busy_o(busy)
  );

  for (genvar g = 0; g < int'(N_SRC); g++) begin : g_lane
    logic [N_SRC-1:0] others_mask;
    assign others_mask = ~(N_SRC'(1) << g);
    clksel_lane u_lane (
      .src_clk(src_clk[g]), .rst_n(rst_n), .selected(lane_sel[g]),
      .others_on(|(gate_raw & others_mask)), .gate_o(gate_raw[g])
    );
  end

  clksel_sync #(.WIDTH(N_SRC)) u_status_sync (
    .clk(clk), .rst_n(rst_n), .d_async(gate_raw), .q_sync(lane_on_s)
  );

  assign passed  = src_clk & gate_raw;
  assign clk_out = |passed;

  // R9: break-before-make across lanes
  a_r9_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_raw));
  // R6: completion only once some parent is gated through
  a_r6_landed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(|lane_on_s));
endmodule

// File: tb/test_trig_clk_select.sv
`timescale 1ns/100ps
module test_trig_clk_select;
  localparam int N = 3;
  localparam int SH = 12;
  localparam logic [31:0] PRE = 32'h2;
  localparam logic [31:0] MAIN = 32'h1;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_clk = '0;
  logic clk_gate_on = 1, sel_we = 0, trig_we = 0;
  logic [31:0] sel_wdata = '0, trig_wdata = '0, sel_rdata, trig_rdata;
  logic clk_out;

  int n_chk = 0, n_fail = 0, short_cnt = 0;
  realtime t_edge = 0;
  int exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;
  always #3.5 src_clk[0] = ~src_clk[0];
  always #5.5 src_clk[1] = ~src_clk[1];
  always #8.5 src_clk[2] = ~src_clk[2];

  trig_clk_select i_trig_clk_select (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .clk_gate_on(clk_gate_on),
    .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_rdata(sel_rdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .trig_rdata(trig_rdata),
    .clk_out(clk_out)
  );

  // R9 phase monitor
  always @(clk_out) begin
    if (rst_n && t_edge > 0 && ($realtime - t_edge) < 3.4) short_cnt++;
    t_edge = $realtime;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_sel(input int code);
    @(negedge clk);
    sel_we = 1;
    sel_wdata = (32'hA5A5_A5A5 & ~(32'h3 << SH)) | (32'(code) << SH);
    @(negedge clk);
    sel_we = 0;
  endtask

  task automatic pulse_trig(input logic [31:0] bits);
    @(negedge clk);
    trig_we = 1;
    trig_wdata = bits;
    @(negedge clk);
    trig_we = 0;
  endtask

  task automatic wait_lvl(input int t, input logic lvl);
    while (src_clk[t] !== lvl) @(src_clk);
  endtask

  task automatic low_window(input string req);
    int highs = 0;
    for (int i = 0; i < 100; i++) begin
      #1;
      if (clk_out) highs++;
    end
    check(highs == 0, req, 32'(highs), 0);
  endtask

  task automatic follows(input int t, input string req);
    for (int k = 0; k < 4; k++) begin
      wait_lvl(t, 0); wait_lvl(t, 1); #1;
      check(clk_out == 1'b1, req, 32'(clk_out), 1);
      wait_lvl(t, 0); #1;
      check(clk_out == 1'b0, req, 32'(clk_out), 0);
    end
  endtask

  task automatic sync_mon();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: pops expected parent after each commit
  initial begin
    forever begin
      int code, guard;
      while (exp_q.size() == 0) @(negedge clk);
      code = exp_q[0];
      guard = 0;
      while (trig_rdata != 0 && guard < 2000) begin @(negedge clk); guard++; end
      check(guard < 2000, "R6 busy clears", trig_rdata, 0);
      if (code < N) follows(code, "R8/R6 output follows parent");
      else begin #80; low_window("R7 void code low"); end
      void'(exp_q.pop_front());
    end
  end

  task automatic commit(input int code);
    wr_sel(code);
    pulse_trig(PRE);
    check(trig_rdata == ((code < N) ? PRE : 0), code < N ? "R6 busy set" : "R7 no busy",
          trig_rdata, (code < N) ? PRE : 0);
    exp_q.push_back(code);
    sync_mon();
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(sel_rdata == (32'd3 << SH), "R1 reset code", sel_rdata, 32'd3 << SH);
    check(trig_rdata == 0, "R6 idle after reset", trig_rdata, 0);
    low_window("R7 reset code low");

    clk_gate_on = 0;
    wr_sel(0);
    check(sel_rdata == (32'd3 << SH), "R2 closed write ignored", sel_rdata, 32'd3 << SH);
    clk_gate_on = 1;
    wr_sel(0);
    check(sel_rdata == 0, "R2/R1 write lands, other bits zero", sel_rdata, 0);
    low_window("R4 pending has no effect");

    pulse_trig(MAIN);
    check(trig_rdata == 0, "R5 main bit ignored", trig_rdata, 0);
    low_window("R5 main bit no switch");

    // commit 0, then try to write while busy
    pulse_trig(PRE);
    check(trig_rdata == PRE, "R6 busy set", trig_rdata, PRE);
    exp_q.push_back(0);
    wr_sel(2);
    sync_mon();
    check(sel_rdata == 0, "R3 busy write ignored", sel_rdata, 0);

    commit(1);
    commit(2);
    commit(0);
    commit(2);
    commit(1);
    commit(3);
    commit(1);

    // trigger with clock disabled
    wr_sel(2);
    clk_gate_on = 0;
    pulse_trig(PRE);
    check(trig_rdata == 0, "R5 closed trigger ignored", trig_rdata, 0);
    follows(1, "R5 output unchanged");
    clk_gate_on = 1;
    commit(0);

    check(short_cnt == 0, "R9 no short phase", 32'(short_cnt), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule